// File: doc/BRIEF.md
# Chainable Snapshot Shift Register

This block holds one bit per input channel in a register of `WIDTH` cells. While the mode input is high the register keeps reloading from the parallel channel inputs on every system clock. When the mode input goes low the contents freeze, and a host then reads them out one bit at a time. Each rising edge of the host's serial clock moves the data one cell toward the output end. The serial data input enters at the far end. Several copies share one serial clock and one mode line, and each serial output feeds the next copy's serial input. One long shift sequence then reads every copy from the serial output of the last copy in the chain.

The mode, serial clock and serial data inputs are asynchronous to the system clock. A synchronizer brings them into the system clock domain, and a shift happens on a detected rising edge of the synchronized serial clock. A fault input and a filter-clock tick input drive an internal hold. The hold is active while the fault is present and out of system reset. It releases on the second tick after the fault clears. While the hold is active the register is cleared and the serial output stays low.

Two state machines run the block. The release machine has four states: HOLD (fault present or just out of reset), WAIT_A (fault gone, waiting for the first tick), WAIT_B (waiting for the second tick) and RUN. Its transitions are HOLD→WAIT_A when the fault is low, WAIT_A→WAIT_B on a tick, WAIT_B→RUN on a tick, and any state→HOLD when the fault is present. The readout machine has three states: HALT, CAPTURE and SHIFT. Its transitions are HALT→CAPTURE or HALT→SHIFT when the hold lifts, chosen by the synchronized mode. CAPTURE→SHIFT happens when the mode falls and SHIFT→CAPTURE when it rises. Any state goes to HALT while the hold is active.

Top module: `serial_snapshot_chain`

## Requirements
- R1: While the synchronized mode input is high and no hold is active, every cell loads its parallel input bit on every system clock.
- R2: Once the block is in serial mode, changes on the parallel inputs leave the register contents unchanged.
- R3: In serial mode the serial output equals the cell at the output end (cell WIDTH-1, holding channel WIDTH-1). Successive shifts therefore present the channels from WIDTH-1 down to 0.
- R4: While the mode input is high, the serial output is 0 whatever the register holds.
- R5: In serial mode, each rising edge of the serial clock moves cell k into cell k+1 and loads the serial input into cell 0.
- R6: A serial clock rise that happens while the block is in parallel mode does not shift the register. This includes a serial clock that is already high when the mode falls.
- R7: With two copies chained (first serial output feeding the second serial input, shared clock and mode), shifting 2×WIDTH times reads the second copy's bits WIDTH-1..0 and then the first copy's bits WIDTH-1..0 from the second copy's serial output.
- R8: While a fault is present, and after system reset, the register is cleared, the serial output is low and shifts are blocked.
- R9: The hold releases only on the second tick pulse after the fault input goes low (or after system reset). Shifts are still blocked between the first and the second tick.
- R10: A falling edge of the serial clock does not shift, and one rising edge causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| fault_i | input | 1 | Fault indication; high forces the hold |
| tick_i | input | 1 | One-cycle filter-clock tick pulse |
| par_i | input | WIDTH | Parallel channel inputs, bit k is channel k |
| mode_par_i | input | 1 | High: parallel capture; low: serial shift (asynchronous) |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdin_i | input | 1 | Serial data input from the previous device in the chain |
| sdout_o | output | 1 | Serial data output; low in parallel mode or under hold |

## Verification
The embedded properties check on every cycle the behaviour that follows from local state:
- the register follows the parallel inputs in CAPTURE;
- it stays stable in SHIFT without a clock rise;
- it moves by exactly one cell on a rise;
- the output is quiet under a held-high mode or an active hold;
- the hold releases only in a cycle that follows a tick.

Only the bench scenarios can show the end-to-end bit order across a full readout, freezing against later parallel changes, and rejection of a serial clock that is already high when the mode falls. They also cover the two-device chain order and the exact tick count after a fault.

// File: rtl/rdchain_pkg.sv
package rdchain_pkg;

    typedef enum logic [1:0] {
        RD_HALT    = 2'd0,
        RD_CAPTURE = 2'd1,
        RD_SHIFT   = 2'd2
    } rd_state_t;

    typedef enum logic [1:0] {
        RL_HOLD   = 2'd0,
        RL_WAIT_A = 2'd1,
        RL_WAIT_B = 2'd2,
        RL_RUN    = 2'd3
    } rl_state_t;

endpackage

// File: rtl/rdchain_sync.sv
module rdchain_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rdchain_release.sv
module rdchain_release
    import rdchain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    input  logic tick_i,
    output logic hold_o
);

    rl_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RL_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (fault_i) begin
            state_d = RL_HOLD;
        end else begin
            unique case (state_q)
                RL_HOLD:   state_d = RL_WAIT_A;
                RL_WAIT_A: if (tick_i) state_d = RL_WAIT_B;
                RL_WAIT_B: if (tick_i) state_d = RL_RUN;
                RL_RUN:    state_d = RL_RUN;
                default:   state_d = RL_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        hold_o = (state_q != RL_RUN);
    end

    AST_FAULT_FORCES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> hold_o); // R8

    AST_RELEASE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> $past(tick_i)); // R9

endmodule

// File: rtl/rdchain_core.sv
module rdchain_core
    import rdchain_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             mode_i,
    input  logic             sclk_i,
    input  logic             sdin_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             sdout_o
);

    localparam int LAST = WIDTH - 1;

    rd_state_t        state_q, state_d;
    logic [WIDTH-1:0] cells_q;
    logic             sclk_prev_q;
    logic             rise;
    logic             load_en, shift_en, clear_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_i;
        end
    end

    assign rise = sclk_i & ~sclk_prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (hold_i) begin
            state_d = RD_HALT;
        end else begin
            unique case (state_q)
                RD_HALT:    state_d = mode_i ? RD_CAPTURE : RD_SHIFT;
                RD_CAPTURE: if (!mode_i) state_d = RD_SHIFT;
                RD_SHIFT:   if (mode_i)  state_d = RD_CAPTURE;
                default:    state_d = RD_HALT;
            endcase
        end
    end

    // outputs
    always_comb begin
        clear_en = (state_q == RD_HALT);
        load_en  = (state_q == RD_CAPTURE);
        shift_en = (state_q == RD_SHIFT) && rise;
        sdout_o  = (state_q == RD_SHIFT) && cells_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else if (clear_en) begin
            cells_q <= '0;
        end else if (load_en) begin
            cells_q <= par_i;
        end else if (shift_en) begin
            cells_q <= {cells_q[LAST-1:0], sdin_i};
        end
    end

    AST_CAPTURE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_CAPTURE) |=> (cells_q == $past(par_i))); // R1

    AST_FROZEN_IN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_SHIFT && !rise) |=> $stable(cells_q)); // R2

    AST_PAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && $past(mode_i)) |-> !sdout_o); // R4

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_SHIFT && rise) |=>
            (cells_q[LAST:1] == $past(cells_q[LAST-1:0]) && cells_q[0] == $past(sdin_i))); // R5

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !sdout_o); // R8

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && $past(hold_i)) |=> (cells_q == '0)); // R8

endmodule

// File: rtl/serial_snapshot_chain.sv
module serial_snapshot_chain
    import rdchain_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_i,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             mode_par_i,
    input  logic             sclk_i,
    input  logic             sdin_i,
    output logic             sdout_o
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_bus, sync_bus;
    logic              hold;

    assign raw_bus = {sdin_i, sclk_i, mode_par_i};

    rdchain_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (sync_bus)
    );

    rdchain_release u_release (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (fault_i),
        .tick_i  (tick_i),
        .hold_o  (hold)
    );

    rdchain_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (hold),
        .mode_i  (sync_bus[0]),
        .sclk_i  (sync_bus[1]),
        .sdin_i  (sync_bus[2]),
        .par_i   (par_i),
        .sdout_o (sdout_o)
    );

endmodule

// File: tb/test_serial_snapshot_chain.sv
`timescale 1ns/1ps
module test_serial_snapshot_chain;

    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0, fault = 1'b0, tick = 1'b0;
    logic         mode = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic [W-1:0] par_a = '0, par_b = '0;
    logic         sdout_a, sdout_b;
    int           checks = 0, fails = 0;
    bit           done = 1'b0;

    serial_snapshot_chain #(.WIDTH(W)) i_serial_snapshot_chain (
        .clk(clk), .rst_n(rst_n), .fault_i(fault), .tick_i(tick),
        .par_i(par_a), .mode_par_i(mode), .sclk_i(sclk),
        .sdin_i(sdin), .sdout_o(sdout_a)
    );

    serial_snapshot_chain #(.WIDTH(W)) i_serial_snapshot_chain_b (
        .clk(clk), .rst_n(rst_n), .fault_i(fault), .tick_i(tick),
        .par_i(par_b), .mode_par_i(mode), .sclk_i(sclk),
        .sdin_i(sdout_a), .sdout_o(sdout_b)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic shift_one(input logic d);
        sdin = d;
        wait_clk(2);
        sclk = 1'b1;
        wait_clk(5);
        sclk = 1'b0;
        wait_clk(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): got hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0]   val;
        logic [2*W-1:0] cat;
        logic [W-1:0]   pa [4];
        logic [W-1:0]   pb [4];

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        chk(sdout_a, 1'b0, "R8 reset state A");
        chk(sdout_b, 1'b0, "R8 reset state B");
        pulse_tick();
        pulse_tick();
        wait_clk(4);

        // R4: output quiet in parallel mode with ones loaded
        par_a = '1; mode = 1'b1;
        wait_clk(6);
        chk(sdout_a, 1'b0, "R4 parallel mode quiet");

        // Sweep of every pattern: capture, freeze, readout, shift-in and re-read
        for (int v = 0; v < (1 << W); v++) begin
            val   = W'(v);
            par_a = val; mode = 1'b1;
            wait_clk(6);
            chk(sdout_a, 1'b0, "R4 quiet while capturing");
            mode = 1'b0;
            wait_clk(6);
            par_a = val ^ 8'hA5;            // R2 must not disturb frozen data
            for (int k = W-1; k >= 0; k--) begin
                chk(sdout_a, val[k], "R1 R2 R3 readout order");
                shift_one(~val[k]);
            end
            for (int k = W-1; k >= 0; k--) begin
                chk(sdout_a, ~val[k], "R5 shifted-in data");
                shift_one(1'b0);
            end
        end

        // R6 / R10: clock activity during capture, clock already high at mode fall
        val = 8'h96; par_a = val; mode = 1'b1;
        wait_clk(6);
        shift_one(1'b1); shift_one(1'b1); shift_one(1'b1);
        sdin = 1'b1;
        sclk = 1'b1;
        wait_clk(4);
        mode = 1'b0;
        wait_clk(6);
        chk(sdout_a, val[W-1], "R6 no shift from high clock at mode fall");
        sclk = 1'b0;
        wait_clk(6);
        chk(sdout_a, val[W-1], "R10 falling edge does not shift");
        for (int k = W-2; k >= 0; k--) begin
            shift_one(1'b0);
            chk(sdout_a, val[k], "R6 R10 one shift per rising edge");
        end

        // R7: two-device chain
        pa[0] = 8'h3C; pb[0] = 8'hE1;
        pa[1] = 8'h01; pb[1] = 8'h80;
        pa[2] = 8'hFF; pb[2] = 8'h00;
        pa[3] = 8'h5A; pb[3] = 8'hC6;
        for (int p = 0; p < 4; p++) begin
            par_a = pa[p]; par_b = pb[p]; mode = 1'b1;
            wait_clk(6);
            mode = 1'b0;
            wait_clk(6);
            cat = {pb[p], pa[p]};
            for (int k = 2*W-1; k >= 0; k--) begin
                chk(sdout_b, cat[k], "R7 chained readout");
                shift_one(1'b0);
            end
        end

        // R8 / R9: fault clears and blocks, release on the second tick
        par_a = '1; mode = 1'b1;
        wait_clk(6);
        mode = 1'b0;
        wait_clk(6);
        chk(sdout_a, 1'b1, "R3 loaded ones visible");
        fault = 1'b1;
        wait_clk(4);
        chk(sdout_a, 1'b0, "R8 fault forces low");
        shift_one(1'b1);
        chk(sdout_a, 1'b0, "R8 shift blocked under fault");
        fault = 1'b0;
        wait_clk(4);
        chk(sdout_a, 1'b0, "R9 held before ticks");
        pulse_tick();
        wait_clk(4);
        for (int i = 0; i < W; i++) begin
            shift_one(1'b1);
            chk(sdout_a, 1'b0, "R9 held after one tick");
        end
        pulse_tick();
        wait_clk(4);
        chk(sdout_a, 1'b0, "R8 register cleared");
        for (int i = 0; i < W; i++) begin
            shift_one(1'b1);
            chk(sdout_a, (i == W-1), "R9 running after second tick");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule